// File: doc/BRIEF.md
# Dual-Port Burst-Addressed Synchronous RAM

This block is a true dual-port static memory of `2**ADDR_W` words, each `DATA_W` bits wide. The defaults are 1K words of 9 bits. Setting `ADDR_W` to 14 gives a 16K-word array, and a 13-bit address gives the half-depth part. Each port runs on its own clock and has its own asynchronous active-low reset. On the rising edge of that clock the port captures its chip selects, write control, output enable, counter controls and write data. Both ports may read or write any word in the same cycle, including the same word.

Each port holds its access address in a register that is also a burst counter. On any edge the counter can be cleared, loaded from the address pins, advanced by one, or left unchanged. A master can therefore start a burst with one load and then step through consecutive words without driving new addresses. A static mode pin on each port selects the read path. In flow-through mode, read data is one cycle behind the capture edge. In pipelined mode, an extra output register adds one more cycle.

Read data leaves on a valid-qualified stream, `dout_*` with `dout_vld_*`, and there is no ready input. The memory cannot stall, so a consumer must take each word in the cycle its valid is high. Back-pressure has to be applied upstream by not issuing reads. All other pins are plain control inputs.

Top module: `dpram_burst`

## Requirements
- R1: A word written through either port is returned by a later read of the same address through either port.
- R2: All control, address and data inputs are acted on only as captured at the rising edge of that port's own clock.
- R3: On each edge the counter takes exactly one action, chosen by priority from the active-low controls: clear to zero (`clr_n` low) first, then load from `addr` (`ld_n` low), then add one (`inc_n` low). When none of these is low, the counter holds its value. The counter value after the edge is the address accessed for that capture.
- R4: Incrementing from address `2**ADDR_W-1` wraps the counter to address 0.
- R5: With `pipe` low (flow-through), read data and `dout_vld` appear after the first edge that follows the capture edge.
- R6: With `pipe` high (pipelined), read data and `dout_vld` appear after the second edge that follows the capture edge.
- R7: A port is selected only when `ce0_n` is low and `ce1` is high at the capture edge. A deselected capture writes nothing and yields no valid read.
- R8: A deselected port's counter still obeys clear, load and increment.
- R9: `oe_n` is captured on each edge. While the captured `oe_n` is high, `dout_vld` is low and `dout` is all zeros.
- R10: Suppose one port writes a word in the same capture cycle that the other port reads it. The read returns the previous contents, and the write is stored.
- R11: After reset, each counter is 0, `dout_vld` is low and `dout` is all zeros. The memory contents are not cleared.
- R12: A write capture (`we_n` low while selected) never raises `dout_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| pipe_a | input | 1 | Port A read mode: 1 pipelined, 0 flow-through |
| ce0_a_n | input | 1 | Port A chip enable, active low |
| ce1_a | input | 1 | Port A chip enable, active high |
| we_a_n | input | 1 | Port A write when low, read when high |
| oe_a_n | input | 1 | Port A output enable, active low |
| ld_a_n | input | 1 | Port A counter load from addr_a, active low |
| inc_a_n | input | 1 | Port A counter increment, active low |
| clr_a_n | input | 1 | Port A counter clear, active low |
| addr_a | input | ADDR_W | Port A load address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data, zero when not valid |
| dout_vld_a | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| pipe_b | input | 1 | Port B read mode: 1 pipelined, 0 flow-through |
| ce0_b_n | input | 1 | Port B chip enable, active low |
| ce1_b | input | 1 | Port B chip enable, active high |
| we_b_n | input | 1 | Port B write when low, read when high |
| oe_b_n | input | 1 | Port B output enable, active low |
| ld_b_n | input | 1 | Port B counter load from addr_b, active low |
| inc_b_n | input | 1 | Port B counter increment, active low |
| clr_b_n | input | 1 | Port B counter clear, active low |
| addr_b | input | ADDR_W | Port B load address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data, zero when not valid |
| dout_vld_b | output | 1 | Port B read data valid |

## Verification
The hardest case to reach from the pins is the same-word collision: one port's write and the other port's read must land on the same array edge. Because of the counter, the accessed address is only known after the capture edge, so both ports are loaded to the same address in the same step and the reads are checked for old and then new contents. A second difficult case is a deselected port that moves its counter while a write is pending. The stimulus loads and steps a deselected port over words prefilled with known values. It then selects the port with the counter on hold, so the word it reads shows where the counter went, and the other port rereads the words the blocked writes aimed at. A long mixed phase drives random selects, output enables and counter actions against a behavioural model on every clock.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_INC   = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic oe;
  } acc_flags_t;

  function automatic cnt_op_t pick_op(input logic clr_n, input logic ld_n,
                                      input logic inc_n);
    if (!clr_n)      return CNT_CLEAR;
    else if (!ld_n)  return CNT_LOAD;
    else if (!inc_n) return CNT_INC;
    else             return CNT_HOLD;
  endfunction

endpackage

// File: rtl/dpb_port_front.sv
module dpb_port_front
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ld_n,
  input  logic              inc_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_din,
  output acc_flags_t        flags
);

  cnt_op_t           op;
  logic [ADDR_W-1:0] cnt_nxt;
  logic              sel;

  assign op  = pick_op(clr_n, ld_n, inc_n);
  assign sel = ~ce0_n & ce1;

  always_comb begin
    unique case (op)
      CNT_CLEAR: cnt_nxt = '0;
      CNT_LOAD:  cnt_nxt = addr;
      CNT_INC:   cnt_nxt = acc_addr + 1'b1;
      default:   cnt_nxt = acc_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr <= '0;
      acc_din  <= '0;
      flags    <= '0;
    end else begin
      acc_addr <= cnt_nxt;
      acc_din  <= din;
      flags.rd <= sel & we_n;
      flags.wr <= sel & ~we_n;
      flags.oe <= ~oe_n;
    end
  end

  // R3
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> acc_addr == '0);
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> acc_addr == $past(addr));
  // R4
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !inc_n) |=> acc_addr == ADDR_W'($past(acc_addr) + 1'b1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && inc_n) |=> $stable(acc_addr));
  // R7
  desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce0_n || !ce1) |=> !flags.wr && !flags.rd);

endmodule

// File: rtl/dpb_lvt_ram.sv
module dpb_lvt_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  // one bank and one live-value bit per writer, so no array has two drivers
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic              tag_a  [DEPTH];
  logic              tag_b  [DEPTH];

  // equal tags: bank A owns the word; unequal tags: bank B owns it
  always_ff @(posedge clk_a) begin
    if (wr_a) begin
      bank_a[addr_a] <= wdata_a;
      tag_a[addr_a]  <= tag_b[addr_a];
    end
    rdata_a <= (tag_a[addr_a] == tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
  end

  always_ff @(posedge clk_b) begin
    if (wr_b) begin
      bank_b[addr_b] <= wdata_b;
      tag_b[addr_b]  <= ~tag_a[addr_b];
    end
    rdata_b <= (tag_a[addr_b] == tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
  end

endmodule

// File: rtl/dpb_read_out.sv
module dpb_read_out #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe,
  input  logic              acc_rd,
  input  logic              oe_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);

  logic              s1_vld;
  logic              s2_vld;
  logic [DATA_W-1:0] s2_dat;
  logic              src_vld;
  logic [DATA_W-1:0] src_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      s2_dat <= '0;
    end else begin
      s1_vld <= acc_rd;
      s2_vld <= s1_vld;
      s2_dat <= rdata;
    end
  end

  always_comb begin
    src_vld  = pipe ? s2_vld : s1_vld;
    src_dat  = pipe ? s2_dat : rdata;
    dout_vld = src_vld & oe_en;
    dout     = dout_vld ? src_dat : '0;
  end

  // R5
  ft_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && dout_vld) |-> $past(acc_rd));
  // R6
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && dout_vld) |-> $past(s1_vld));
  // R9
  oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_en |-> (!dout_vld && dout == '0));

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              pipe_a,
  input  logic              ce0_a_n,
  input  logic              ce1_a,
  input  logic              we_a_n,
  input  logic              oe_a_n,
  input  logic              ld_a_n,
  input  logic              inc_a_n,
  input  logic              clr_a_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              dout_vld_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              pipe_b,
  input  logic              ce0_b_n,
  input  logic              ce1_b,
  input  logic              we_b_n,
  input  logic              oe_b_n,
  input  logic              ld_b_n,
  input  logic              inc_b_n,
  input  logic              clr_b_n,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              dout_vld_b
);

  localparam int NPORT = 2;

  logic [NPORT-1:0] clk_v, rst_v, pipe_v, ce0_v, ce1_v, we_v, oe_v, ld_v, inc_v, clr_v;
  logic [ADDR_W-1:0] addr_v     [NPORT];
  logic [DATA_W-1:0] din_v      [NPORT];
  logic [ADDR_W-1:0] acc_addr_v [NPORT];
  logic [DATA_W-1:0] acc_din_v  [NPORT];
  acc_flags_t        flags_v    [NPORT];
  logic [DATA_W-1:0] rdata_v    [NPORT];
  logic [DATA_W-1:0] dout_v     [NPORT];
  logic              vld_v      [NPORT];

  assign clk_v  = {clk_b, clk_a};
  assign rst_v  = {rst_b_n, rst_a_n};
  assign pipe_v = {pipe_b, pipe_a};
  assign ce0_v  = {ce0_b_n, ce0_a_n};
  assign ce1_v  = {ce1_b, ce1_a};
  assign we_v   = {we_b_n, we_a_n};
  assign oe_v   = {oe_b_n, oe_a_n};
  assign ld_v   = {ld_b_n, ld_a_n};
  assign inc_v  = {inc_b_n, inc_a_n};
  assign clr_v  = {clr_b_n, clr_a_n};
  assign addr_v[0] = addr_a;
  assign addr_v[1] = addr_b;
  assign din_v[0]  = din_a;
  assign din_v[1]  = din_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpb_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk      (clk_v[p]),
      .rst_n    (rst_v[p]),
      .ce0_n    (ce0_v[p]),
      .ce1      (ce1_v[p]),
      .we_n     (we_v[p]),
      .oe_n     (oe_v[p]),
      .ld_n     (ld_v[p]),
      .inc_n    (inc_v[p]),
      .clr_n    (clr_v[p]),
      .addr     (addr_v[p]),
      .din      (din_v[p]),
      .acc_addr (acc_addr_v[p]),
      .acc_din  (acc_din_v[p]),
      .flags    (flags_v[p])
    );

    dpb_read_out #(.DATA_W(DATA_W)) u_out (
      .clk      (clk_v[p]),
      .rst_n    (rst_v[p]),
      .pipe     (pipe_v[p]),
      .acc_rd   (flags_v[p].rd),
      .oe_en    (flags_v[p].oe),
      .rdata    (rdata_v[p]),
      .dout     (dout_v[p]),
      .dout_vld (vld_v[p])
    );
  end

  dpb_lvt_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_a   (clk_a),
    .wr_a    (flags_v[0].wr),
    .addr_a  (acc_addr_v[0]),
    .wdata_a (acc_din_v[0]),
    .rdata_a (rdata_v[0]),
    .clk_b   (clk_b),
    .wr_b    (flags_v[1].wr),
    .addr_b  (acc_addr_v[1]),
    .wdata_b (acc_din_v[1]),
    .rdata_b (rdata_v[1])
  );

  assign dout_a     = dout_v[0];
  assign dout_vld_a = vld_v[0];
  assign dout_b     = dout_v[1];
  assign dout_vld_b = vld_v[1];

  // R12
  write_no_valid_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (!ce0_a_n && ce1_a && !we_a_n && !pipe_a) |=> ##1 !dout_vld_a);

endmodule

// File: tb/dpram_burst_test.sv
`timescale 1ns/1ps
module dpram_burst_test;

  localparam int AW    = 10;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] pipe, ce0n, ce1, wen, oen, ldn, incn, clrn;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] din  [2];
  logic [DW-1:0] dout_a, dout_b;
  logic vld_a, vld_b;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R11";

  int mem [DEPTH];
  int m_cnt [2], m_accr [2], m_accw [2], m_acca [2], m_accd [2], m_oe [2];
  int m_s1v [2], m_s1d [2], m_s2v [2], m_s2d [2];
  int exp_v [2], exp_d [2];

  always #4 clk = ~clk;

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_a(clk), .rst_a_n(rst_n), .pipe_a(pipe[0]), .ce0_a_n(ce0n[0]), .ce1_a(ce1[0]),
    .we_a_n(wen[0]), .oe_a_n(oen[0]), .ld_a_n(ldn[0]), .inc_a_n(incn[0]), .clr_a_n(clrn[0]),
    .addr_a(addr[0]), .din_a(din[0]), .dout_a(dout_a), .dout_vld_a(vld_a),
    .clk_b(clk), .rst_b_n(rst_n), .pipe_b(pipe[1]), .ce0_b_n(ce0n[1]), .ce1_b(ce1[1]),
    .we_b_n(wen[1]), .oe_b_n(oen[1]), .ld_b_n(ldn[1]), .inc_b_n(incn[1]), .clr_b_n(clrn[1]),
    .addr_b(addr[1]), .din_b(din[1]), .dout_b(dout_b), .dout_vld_b(vld_b)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL %s watchdog expired actual 0 expected 1", cur_req);
    summary();
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, expv);
    end
  endtask

  // port p: chip enables, we_n, oe_n, ld_n, inc_n, clr_n, address, data
  task automatic drive(input int p, input bit c0n, input bit c1, input bit w_n, input bit o_n,
                       input bit l_n, input bit i_n, input bit r_n, input int a, input int d);
    ce0n[p] = c0n; ce1[p] = c1; wen[p] = w_n; oen[p] = o_n;
    ldn[p] = l_n; incn[p] = i_n; clrn[p] = r_n;
    addr[p] = AW'(a); din[p] = DW'(d);
  endtask

  task automatic idle(input int p);
    drive(p, 1, 0, 1, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic model_edge();
    int rv [2];
    for (int p = 0; p < 2; p++) rv[p] = m_accr[p] ? mem[m_acca[p]] : -1;
    for (int p = 0; p < 2; p++) begin
      m_s2v[p] = m_s1v[p]; m_s2d[p] = m_s1d[p];
      m_s1v[p] = m_accr[p]; m_s1d[p] = rv[p];
    end
    for (int p = 0; p < 2; p++) if (m_accw[p] != 0) mem[m_acca[p]] = m_accd[p];
    for (int p = 0; p < 2; p++) begin
      int sel;
      if (!clrn[p])      m_cnt[p] = 0;
      else if (!ldn[p])  m_cnt[p] = int'(addr[p]);
      else if (!incn[p]) m_cnt[p] = (m_cnt[p] + 1) % DEPTH;
      sel = (!ce0n[p] && ce1[p]) ? 1 : 0;
      m_accr[p] = (sel != 0 && wen[p]) ? 1 : 0;
      m_accw[p] = (sel != 0 && !wen[p]) ? 1 : 0;
      m_acca[p] = m_cnt[p];
      m_accd[p] = int'(din[p]);
      m_oe[p]   = oen[p] ? 0 : 1;
      exp_v[p]  = (pipe[p] ? m_s2v[p] : m_s1v[p]) & m_oe[p];
      exp_d[p]  = (exp_v[p] != 0) ? (pipe[p] ? m_s2d[p] : m_s1d[p]) : 0;
    end
  endtask

  task automatic compare();
    int av, ad;
    for (int p = 0; p < 2; p++) begin
      av = (p == 0) ? int'(vld_a) : int'(vld_b);
      ad = (p == 0) ? int'(dout_a) : int'(dout_b);
      chk(av == exp_v[p], (p == 0) ? "port A valid" : "port B valid", av, exp_v[p]);
      if (exp_d[p] != -1)
        chk(ad == exp_d[p], (p == 0) ? "port A data" : "port B data", ad, exp_d[p]);
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic hold_steps(input int n);
    idle(0); idle(1);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = -1;
    for (int p = 0; p < 2; p++) begin
      m_cnt[p] = 0; m_accr[p] = 0; m_accw[p] = 0; m_acca[p] = 0; m_accd[p] = 0; m_oe[p] = 0;
      m_s1v[p] = 0; m_s1d[p] = 0; m_s2v[p] = 0; m_s2d[p] = 0; exp_v[p] = 0; exp_d[p] = 0;
    end
    pipe = 2'b01;
    rst_n = 1'b0;
    idle(0); idle(1);
    repeat (3) @(negedge clk);
    // R11: outputs quiet while and right after reset
    cur_req = "R11";
    chk(vld_a == 1'b0 && dout_a == '0, "A reset outputs", int'(dout_a), 0);
    chk(vld_b == 1'b0 && dout_b == '0, "B reset outputs", int'(dout_b), 0);
    rst_n = 1'b1;
    step();

    // R3/R12: burst write from A using load then increment
    cur_req = "R12";
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 1, 0, 0, (i == 0) ? 0 : 1, (i == 0) ? 1 : 0, 1, 16, 100 + i);
      step();
    end
    drive(1, 0, 1, 0, 0, 0, 1, 1, 30, 130);
    idle(0); step();
    for (int i = 1; i < 12; i++) begin
      drive(1, 0, 1, 0, 0, 1, 0, 1, 0, 130 + i);
      step();
    end
    hold_steps(2);

    // R1/R5: B reads A's burst in flow-through mode
    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 1, 1, 0, (i == 0) ? 0 : 1, (i == 0) ? 1 : 0, 1, 16, 0);
      step();
    end
    hold_steps(2);
    // R1/R6: A reads its own burst in pipelined mode
    cur_req = "R6";
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 1, 1, 0, (i == 0) ? 0 : 1, (i == 0) ? 1 : 0, 1, 16, 0);
      step();
    end
    hold_steps(3);

    // R3: priority clear > load > increment > hold
    cur_req = "R3";
    drive(1, 0, 1, 0, 0, 0, 1, 1, 0, 77); step();
    idle(1);
    drive(0, 0, 1, 1, 0, 0, 0, 0, 16, 0); step();
    drive(0, 0, 1, 1, 0, 0, 0, 1, 20, 0); step();
    drive(0, 0, 1, 1, 0, 1, 1, 1, 5, 0);  step();
    drive(0, 0, 1, 1, 0, 1, 0, 1, 5, 0);  step();
    hold_steps(3);

    // R4: wrap from the top address to zero
    cur_req = "R4";
    drive(0, 0, 1, 0, 0, 0, 1, 1, DEPTH - 1, 55); step();
    drive(0, 0, 1, 0, 0, 1, 0, 1, 0, 56); step();
    idle(0);
    drive(1, 0, 1, 1, 0, 0, 1, 1, DEPTH - 1, 0); step();
    drive(1, 0, 1, 1, 0, 1, 0, 1, 0, 0); step();
    hold_steps(3);

    // R7/R8: deselected port moves its counter but never writes
    cur_req = "R8";
    drive(0, 1, 1, 0, 0, 0, 1, 1, 30, 200); step();
    drive(0, 0, 0, 0, 0, 1, 0, 1, 0, 201); step();
    drive(0, 1, 0, 0, 0, 1, 0, 1, 0, 202); step();
    drive(0, 0, 1, 1, 0, 1, 1, 1, 0, 0); step();
    idle(0); step();
    cur_req = "R7";
    drive(1, 0, 1, 1, 0, 0, 1, 1, 30, 0); step();
    drive(1, 0, 1, 1, 0, 1, 0, 1, 0, 0); step();
    drive(1, 0, 1, 1, 0, 1, 0, 1, 0, 0); step();
    drive(1, 0, 0, 1, 0, 1, 0, 1, 0, 0); step();
    hold_steps(3);

    // R9: output enable blanks the bus
    cur_req = "R9";
    pipe[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      drive(1, 0, 1, 1, i % 2, (i == 0) ? 0 : 1, (i == 0) ? 1 : 0, 1, 16, 0);
      step();
    end
    hold_steps(3);

    // R10: same word written by A and read by B in one capture
    cur_req = "R10";
    drive(0, 0, 1, 0, 0, 0, 1, 1, 40, 1);
    drive(1, 0, 1, 1, 0, 0, 1, 1, 40, 0); step();
    idle(0);
    drive(1, 0, 1, 1, 0, 1, 1, 1, 0, 0); step();
    hold_steps(3);

    // R2/R1: mixed random traffic, A reads and writes, B only reads
    cur_req = "R2";
    for (int blk = 0; blk < 4; blk++) begin
      pipe = 2'(blk);
      for (int i = 0; i < 600; i++) begin
        int ctl;
        ctl = int'($urandom);
        drive(0, (ctl % 8) == 0, (ctl % 11) != 0, ((ctl >> 4) % 3) == 0, ((ctl >> 6) % 7) == 0,
              ((ctl >> 9) % 4) != 0, ((ctl >> 11) % 3) == 0, ((ctl >> 13) % 29) != 0,
              (ctl >> 16) % 64, (ctl >> 20) % 512);
        ctl = int'($urandom);
        drive(1, (ctl % 9) == 0, 1, 1, ((ctl >> 6) % 7) == 0,
              ((ctl >> 9) % 4) != 0, ((ctl >> 11) % 3) == 0, ((ctl >> 13) % 31) != 0,
              (ctl >> 16) % 64, 0);
        step();
      end
      hold_steps(3);
    end

    summary();
  end

endmodule